// File: doc/BRIEF.md
# NAND Flash Device-Side Command Front End

This block sits behind the pins of a NAND flash die. It turns the bus strobes into command, address and data-in events inside one synchronous clock domain. The strobes are chip select, command strobe, address strobe, write strobe, read strobe and write lock. Each strobe that can change at any time passes through a two-stage synchroniser. Its edges are found by comparing the synchronised level with the level one cycle earlier. The data lines and the two latch-select strobes are sampled in the cycle where a write-strobe rise is detected, so the host must hold them steady around that edge.

A column pointer is loaded by the first address byte and steps on every falling read strobe. The row bytes that follow are stored low byte first. A countdown timer stands in for the array operation. The ready line drops while that timer runs. What chip select may do during a busy phase depends on the operation. Program and erase ignore chip select. A read is abandoned when chip select rises, unless the build option that makes chip select irrelevant during reads is set.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset the following all hold: `rb_n` is 1, `seq_err` is 0, `col_addr` is 0, and all three event pulses are 0.
- R2: For the first `RECOVERY_CYC` clock cycles after reset, no bus write is acted on and no event pulse appears.
- R3: A bus write is a synchronised rising edge of `we_n` while the synchronised `ce_n` is 0. It produces its event three clock edges after `we_n` goes high. When `cle`=1 and `ale`=0, `io_in[7:0]` is stored in `cmd_code` and `cmd_stb` pulses for one cycle.
- R4: A write with `ale`=1 and `cle`=0 pulses `addr_stb`. Address byte 0 loads `col_addr`. Bytes 1..`ROW_BYTES` load `row_addr` byte lanes 0 upward. Any command resets the byte count to 0.
- R5: A write with `cle`=0 and `ale`=0 stores the full `io_in` width in `din` and pulses `din_stb`. Commands and addresses use only `io_in[7:0]`.
- R6: A write with both `cle` and `ale` high changes no register except `seq_err`. `seq_err` goes to 1 and stays there until reset.
- R7: A synchronised falling edge of `re_n` while `ce_n` is 0 and the block is idle adds one to `col_addr`, wrapping at its width. With `ce_n` high it has no effect.
- R8: While `wp_n` is 0, program (8'h10) and erase (8'hD0) commands are still latched but start no busy phase.
- R9: After read command 8'h00, the address byte that completes 1+`ROW_BYTES` bytes starts a read busy phase of `T_READ` cycles.
- R10: Commands 8'h10 and 8'hD0 with `wp_n`=1 start busy phases of `T_PROG` and `T_ERASE` cycles. Chip select going high does not shorten them.
- R11: With `CE_DONT_CARE`=0, chip select going high during a read busy phase ends it and returns `rb_n` to 1. With `CE_DONT_CARE`=1, the read runs to its full length.
- R12: `rb_n` is 0 exactly while a busy phase runs. Bus writes and read strobes during that time produce no event and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe; latches on its rising edge |
| re_n | input | 1 | Read strobe; steps the column on its falling edge |
| wp_n | input | 1 | Write lock, active low |
| io_in | input | DATA_W | Bus data lines |
| cmd_stb | output | 1 | One-cycle pulse on a latched command |
| cmd_code | output | 8 | Last latched command byte |
| addr_stb | output | 1 | One-cycle pulse on a latched address byte |
| col_addr | output | COL_W | Column pointer |
| row_addr | output | 8*ROW_BYTES | Row address bytes |
| din_stb | output | 1 | One-cycle pulse on a latched data word |
| din | output | DATA_W | Last latched data word |
| rb_n | output | 1 | Ready (1) / busy (0) |
| seq_err | output | 1 | Sticky flag for a write with both latch selects high |

## Verification
The assertions assume that `cle`, `ale`, `wp_n` and `io_in` do not change within the few cycles around a detected write-strobe rise. This lets a value one cycle in the past stand for the value at the edge. They also assume that every strobe level lasts longer than the synchroniser depth, so that no edge is lost. The bench changes inputs only on falling clock edges. It holds each strobe level for at least three cycles and keeps the latch selects and data steady for four cycles after the write strobe rises. It changes `wp_n` only while the bus is quiet.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_PROG  = 2'd2,
      OP_ERASE = 2'd3
   } nfc_op_e;

   localparam logic [7:0] CMD_READ  = 8'h00;
   localparam logic [7:0] CMD_PROG  = 8'h10;
   localparam logic [7:0] CMD_ERASE = 8'hD0;

   localparam int SYNC_LEVEL = 0;
   localparam int SYNC_RISE  = 1;
   localparam int SYNC_FALL  = 2;
endpackage

// File: rtl/nfc_strobe_sync.sv
module nfc_strobe_sync #(
   parameter int MODE   = 0,
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic q
);
   logic [STAGES-1:0] sr;
   logic              lvl;

   if (STAGES < 2) begin : g_bad_stages
      $error("nfc_strobe_sync: STAGES must be at least 2");
   end
   if (MODE < 0 || MODE > 2) begin : g_bad_mode
      $error("nfc_strobe_sync: MODE out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-2:0], raw};
   end
   assign lvl = sr[STAGES-1];

   if (MODE == 0) begin : g_level
      assign q = lvl;
   end else begin : g_edge
      logic prv;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prv <= 1'b1;
         else        prv <= lvl;
      end
      if (MODE == 1) begin : g_rise
         assign q = lvl & ~prv;
      end else begin : g_fall
         assign q = ~lvl & prv;
      end
   end
endmodule

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer
   import nfc_pkg::*;
#(
   parameter int T_READ       = 30,
   parameter int T_PROG       = 40,
   parameter int T_ERASE      = 50,
   parameter bit CE_DONT_CARE = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  nfc_op_e start_op,
   input  logic    ce_low,
   output nfc_op_e op
);
   localparam int TMAX = (T_READ > T_PROG) ? ((T_READ > T_ERASE) ? T_READ : T_ERASE)
                                           : ((T_PROG > T_ERASE) ? T_PROG : T_ERASE);
   localparam int TW   = $clog2(TMAX + 1);

   logic [TW-1:0] cnt, ld;
   logic          abort;

   if (T_READ < 1 || T_PROG < 1 || T_ERASE < 1) begin : g_bad_time
      $error("nfc_busy_timer: busy durations must be at least 1");
   end

   always_comb begin
      case (start_op)
         OP_READ:  ld = TW'(T_READ - 1);
         OP_PROG:  ld = TW'(T_PROG - 1);
         OP_ERASE: ld = TW'(T_ERASE - 1);
         default:  ld = '0;
      endcase
   end

   if (CE_DONT_CARE) begin : g_ce_free
      assign abort = 1'b0;
   end else begin : g_ce_abort
      assign abort = (op == OP_READ) & ~ce_low;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op  <= OP_IDLE;
         cnt <= '0;
      end else if (start) begin
         op  <= start_op;
         cnt <= ld;
      end else if (op != OP_IDLE) begin
         if (abort || cnt == '0) begin
            op  <= OP_IDLE;
            cnt <= '0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
   import nfc_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int COL_W        = 8,
   parameter int ROW_BYTES    = 2,
   parameter int RECOVERY_CYC = 20,
   parameter int T_READ       = 30,
   parameter int T_PROG       = 40,
   parameter int T_ERASE      = 50,
   parameter bit CE_DONT_CARE = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ce_n,
   input  logic                   cle,
   input  logic                   ale,
   input  logic                   we_n,
   input  logic                   re_n,
   input  logic                   wp_n,
   input  logic [DATA_W-1:0]      io_in,
   output logic                   cmd_stb,
   output logic [7:0]             cmd_code,
   output logic                   addr_stb,
   output logic [COL_W-1:0]       col_addr,
   output logic [8*ROW_BYTES-1:0] row_addr,
   output logic                   din_stb,
   output logic [DATA_W-1:0]      din,
   output logic                   rb_n,
   output logic                   seq_err
);
   localparam int NADDR = 1 + ROW_BYTES;
   localparam int AW    = $clog2(NADDR + 1);
   localparam int RW    = $clog2(RECOVERY_CYC + 1);

   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
      $error("nand_cmd_front: DATA_W must be 8 or 16");
   end
   if (COL_W < 8) begin : g_bad_col
      $error("nand_cmd_front: COL_W must be at least 8");
   end
   if (ROW_BYTES < 1 || ROW_BYTES > 4) begin : g_bad_row
      $error("nand_cmd_front: ROW_BYTES must be 1 to 4");
   end
   if (RECOVERY_CYC < 1) begin : g_bad_rec
      $error("nand_cmd_front: RECOVERY_CYC must be at least 1");
   end

   logic          we_rise, re_fall, ce_sync_n;
   logic [RW-1:0] rec_cnt;
   logic          rec_done, idle, accept, step_ok;
   logic          is_cmd, is_addr, is_both;
   logic [AW-1:0] addr_cnt;
   logic          rd_armed;
   logic          start;
   nfc_op_e       start_op, busy_op;

   nfc_strobe_sync #(.MODE(SYNC_RISE),  .STAGES(2)) u_we (.clk(clk), .rst_n(rst_n), .raw(we_n), .q(we_rise));
   nfc_strobe_sync #(.MODE(SYNC_FALL),  .STAGES(2)) u_re (.clk(clk), .rst_n(rst_n), .raw(re_n), .q(re_fall));
   nfc_strobe_sync #(.MODE(SYNC_LEVEL), .STAGES(2)) u_ce (.clk(clk), .rst_n(rst_n), .raw(ce_n), .q(ce_sync_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rec_cnt <= '0;
      else if (!rec_done) rec_cnt <= rec_cnt + 1'b1;
   end
   assign rec_done = (rec_cnt == RW'(RECOVERY_CYC));

   assign idle    = (busy_op == OP_IDLE);
   assign accept  = we_rise & ~ce_sync_n & rec_done & idle;
   assign step_ok = re_fall & ~ce_sync_n & rec_done & idle;
   assign is_both = cle & ale;
   assign is_cmd  = cle & ~ale;
   assign is_addr = ale & ~cle;

   always_comb begin
      start    = 1'b0;
      start_op = OP_IDLE;
      if (accept && is_cmd && wp_n && io_in[7:0] == CMD_PROG) begin
         start    = 1'b1;
         start_op = OP_PROG;
      end else if (accept && is_cmd && wp_n && io_in[7:0] == CMD_ERASE) begin
         start    = 1'b1;
         start_op = OP_ERASE;
      end else if (accept && is_addr && rd_armed && addr_cnt == AW'(NADDR - 1)) begin
         start    = 1'b1;
         start_op = OP_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stb  <= 1'b0;
         cmd_code <= '0;
         addr_stb <= 1'b0;
         addr_cnt <= '0;
         rd_armed <= 1'b0;
         row_addr <= '0;
         din_stb  <= 1'b0;
         din      <= '0;
         seq_err  <= 1'b0;
      end else begin
         cmd_stb  <= accept & is_cmd;
         addr_stb <= accept & is_addr;
         din_stb  <= accept & ~cle & ~ale;
         if (accept && is_both) seq_err <= 1'b1;
         if (accept && is_cmd) begin
            cmd_code <= io_in[7:0];
            addr_cnt <= '0;
            rd_armed <= (io_in[7:0] == CMD_READ);
         end
         if (accept && is_addr) begin
            for (int i = 0; i < ROW_BYTES; i++) begin
               if (addr_cnt == AW'(i + 1)) row_addr[8*i +: 8] <= io_in[7:0];
            end
            if (addr_cnt != AW'(NADDR)) addr_cnt <= addr_cnt + 1'b1;
            if (start) rd_armed <= 1'b0;
         end
         if (accept && !cle && !ale) din <= io_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      col_addr <= '0;
      else if (accept && is_addr && addr_cnt == '0)    col_addr <= COL_W'(io_in[7:0]);
      else if (step_ok)                                col_addr <= col_addr + 1'b1;
   end

   nfc_busy_timer #(
      .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .CE_DONT_CARE(CE_DONT_CARE)
   ) u_busy (
      .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
      .ce_low(~ce_sync_n), .op(busy_op)
   );

   assign rb_n = (busy_op == OP_IDLE);
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker
   import nfc_pkg::*;
#(
   parameter int COL_W        = 8,
   parameter int RECOVERY_CYC = 20,
   parameter int T_READ       = 30,
   parameter int T_PROG       = 40,
   parameter int T_ERASE      = 50,
   parameter bit CE_DONT_CARE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cle,
   input logic             ale,
   input logic             wp_n,
   input logic             cmd_stb,
   input logic             addr_stb,
   input logic             din_stb,
   input logic [COL_W-1:0] col_addr,
   input logic             rb_n,
   input logic             seq_err,
   input nfc_op_e          busy_op
);
   int since_rst;
   int low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= 0;
         low_len   <= 0;
      end else begin
         if (since_rst < RECOVERY_CYC) since_rst <= since_rst + 1;
         low_len <= rb_n ? 0 : low_len + 1;
      end
   end

   a_r2_quiet_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < RECOVERY_CYC) |-> !(cmd_stb || addr_stb || din_stb));

   a_r3_cmd_needs_cle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> $past(cle && !ale));

   a_r4_addr_needs_ale: assert property (@(posedge clk) disable iff (!rst_n)
      addr_stb |-> $past(ale && !cle));

   a_r5_data_needs_neither: assert property (@(posedge clk) disable iff (!rst_n)
      din_stb |-> $past(!cle && !ale));

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);

   a_r7_col_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (col_addr != $past(col_addr) && !addr_stb) |-> (col_addr == $past(col_addr) + 1'b1));

   a_r8_lock_blocks_pe: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rb_n) && $past(!wp_n)) |-> (busy_op == OP_READ));

   a_r10_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rb_n) && $past(busy_op) == OP_PROG) |-> (low_len == T_PROG));

   a_r10_erase_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rb_n) && $past(busy_op) == OP_ERASE) |-> (low_len == T_ERASE));

   a_r11_read_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rb_n) && $past(busy_op) == OP_READ) |->
         (low_len == T_READ || (!CE_DONT_CARE && low_len < T_READ)));

   a_r12_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rb_n) |-> !(cmd_stb || addr_stb || din_stb));
endmodule

bind nand_cmd_front nfc_checker #(
   .COL_W(COL_W), .RECOVERY_CYC(RECOVERY_CYC), .T_READ(T_READ),
   .T_PROG(T_PROG), .T_ERASE(T_ERASE), .CE_DONT_CARE(CE_DONT_CARE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .wp_n(wp_n),
   .cmd_stb(cmd_stb), .addr_stb(addr_stb), .din_stb(din_stb),
   .col_addr(col_addr), .rb_n(rb_n), .seq_err(seq_err), .busy_op(busy_op)
);

// File: tb/sim_nand_cmd_front.sv
`timescale 1ns/1ps
module sim_nand_cmd_front;
   localparam int DW  = 16;
   localparam int CW  = 8;
   localparam int RB  = 2;
   localparam int REC = 20;
   localparam int TR  = 30;
   localparam int TP  = 40;
   localparam int TE  = 50;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
   logic [DW-1:0] io = '0;

   logic          cmd_stb, addr_stb, din_stb, rb_n, seq_err;
   logic [7:0]    cmd_code;
   logic [CW-1:0] col_addr;
   logic [8*RB-1:0] row_addr;
   logic [DW-1:0] din;

   logic          x_cs, x_as, x_ds, rb_n_1, x_err;
   logic [7:0]    x_cc;
   logic [CW-1:0] x_col;
   logic [8*RB-1:0] x_row;
   logic [DW-1:0] x_din;

   nand_cmd_front #(.DATA_W(DW), .COL_W(CW), .ROW_BYTES(RB), .RECOVERY_CYC(REC),
      .T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .CE_DONT_CARE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .wp_n(wp_n), .io_in(io), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
      .addr_stb(addr_stb), .col_addr(col_addr), .row_addr(row_addr), .din_stb(din_stb),
      .din(din), .rb_n(rb_n), .seq_err(seq_err));

   nand_cmd_front #(.DATA_W(DW), .COL_W(CW), .ROW_BYTES(RB), .RECOVERY_CYC(REC),
      .T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .CE_DONT_CARE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .wp_n(wp_n), .io_in(io), .cmd_stb(x_cs), .cmd_code(x_cc),
      .addr_stb(x_as), .col_addr(x_col), .row_addr(x_row), .din_stb(x_ds),
      .din(x_din), .rb_n(rb_n_1), .seq_err(x_err));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got 'h%0h, expected 'h%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: strobe history in a queue, state in plain integers
   bit q_we[$], q_re[$], q_ce[$];
   int m_rec, m_op, m_left, m_acnt;
   bit m_armed, m_cs, m_as, m_ds, m_err;
   logic [7:0]    m_cmd, m_col;
   logic [8*RB-1:0] m_row;
   logic [DW-1:0] m_din;

   always @(posedge clk) begin
      if (!rst_n) begin
         q_we = '{1, 1, 1}; q_re = '{1, 1, 1}; q_ce = '{1, 1, 1};
         m_rec = 0; m_op = 0; m_left = 0; m_acnt = 0; m_armed = 0;
         m_cs = 0; m_as = 0; m_ds = 0; m_err = 0;
         m_cmd = 0; m_col = 0; m_row = 0; m_din = 0;
      end else begin
         bit rise, fall, celo, ready, idle;
         rise  = q_we[1] && !q_we[2];
         fall  = !q_re[1] && q_re[2];
         celo  = !q_ce[1];
         ready = (m_rec == REC);
         if (!ready) m_rec++;
         idle = (m_op == 0);
         m_cs = 0; m_as = 0; m_ds = 0;
         if (!idle) begin
            if (m_op == 1 && !celo) m_op = 0;
            else begin
               m_left--;
               if (m_left == 0) m_op = 0;
            end
         end
         if (idle && ready && celo && rise) begin
            if (cle && ale) m_err = 1;
            else if (cle) begin
               m_cs = 1; m_cmd = io[7:0]; m_acnt = 0; m_armed = (io[7:0] == 8'h00);
               if (wp_n && io[7:0] == 8'h10) begin m_op = 2; m_left = TP; end
               if (wp_n && io[7:0] == 8'hD0) begin m_op = 3; m_left = TE; end
            end else if (ale) begin
               m_as = 1;
               if (m_acnt == 0) m_col = io[7:0];
               else if (m_acnt <= RB) m_row[8*(m_acnt-1) +: 8] = io[7:0];
               if (m_armed && m_acnt == RB) begin m_op = 1; m_left = TR; m_armed = 0; end
               if (m_acnt < RB + 1) m_acnt++;
            end else begin
               m_ds = 1; m_din = io;
            end
         end else if (idle && ready && celo && fall) begin
            m_col = m_col + 8'd1;
         end
         void'(q_we.pop_back()); q_we.push_front(we_n);
         void'(q_re.pop_back()); q_re.push_front(re_n);
         void'(q_ce.pop_back()); q_ce.push_front(ce_n);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cmd_stb == m_cs,   "R3 cmd_stb", cmd_stb, m_cs);
         chk(cmd_code == m_cmd, "R3 cmd_code", cmd_code, m_cmd);
         chk(addr_stb == m_as,  "R4 addr_stb", addr_stb, m_as);
         chk(col_addr == m_col, "R4 col_addr", col_addr, m_col);
         chk(row_addr == m_row, "R4 row_addr", row_addr, m_row);
         chk(din_stb == m_ds,   "R5 din_stb", din_stb, m_ds);
         chk(din == m_din,      "R5 din", din, m_din);
         chk(seq_err == m_err,  "R6 seq_err", seq_err, m_err);
         chk(rb_n == (m_op == 0), "R12 rb_n", rb_n, (m_op == 0));
      end
   end

   task automatic bus_wr(input logic c, input logic a, input logic [DW-1:0] d);
      @(negedge clk); cle = c; ale = a; io = d; we_n = 1'b0;
      repeat (3) @(negedge clk);
      we_n = 1'b1;
      repeat (4) @(negedge clk);
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic re_pulse();
      @(negedge clk); re_n = 1'b0;
      repeat (3) @(negedge clk);
      re_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (rb_n == 1'b0 && n < 500) begin n++; @(negedge clk); end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      ce_n = 1'b0;
      @(negedge clk);
      // R1: state right after reset
      chk(rb_n == 1'b1,    "R1 rb_n", rb_n, 1);
      chk(seq_err == 1'b0, "R1 seq_err", seq_err, 0);
      chk(col_addr == '0,  "R1 col_addr", col_addr, 0);
      chk(!(cmd_stb || addr_stb || din_stb), "R1 pulses", {cmd_stb, addr_stb, din_stb}, 0);
      // R2: write inside recovery window is dropped
      bus_wr(1'b1, 1'b0, 16'h0070);
      chk(cmd_code == 8'h00, "R2 cmd_code", cmd_code, 8'h00);
      repeat (25) @(negedge clk);

      // R3, R5: command uses low byte only
      bus_wr(1'b1, 1'b0, 16'hAB70);
      chk(cmd_code == 8'h70, "R3 cmd_code", cmd_code, 8'h70);
      // R5: data word keeps full width
      bus_wr(1'b0, 1'b0, 16'hBEEF);
      chk(din == 16'hBEEF, "R5 din", din, 16'hBEEF);

      // R4, R9: read with column and two row bytes
      bus_wr(1'b1, 1'b0, 16'h0000);
      bus_wr(1'b0, 1'b1, 16'h0005);
      bus_wr(1'b0, 1'b1, 16'h0034);
      chk(rb_n == 1'b1, "R9 no busy before last byte", rb_n, 1);
      bus_wr(1'b0, 1'b1, 16'h0012);
      chk(row_addr == 16'h1234, "R4 row_addr", row_addr, 16'h1234);
      chk(col_addr == 8'h05, "R4 col_addr", col_addr, 8'h05);
      wait_ready(n);
      chk(n == TR - 1, "R9 read busy length", n, TR - 1);
      repeat (3) @(negedge clk);

      // R7: read strobe steps column
      re_pulse(); re_pulse(); re_pulse();
      chk(col_addr == 8'h08, "R7 col step", col_addr, 8'h08);
      ce_n = 1'b1; repeat (3) @(negedge clk);
      re_pulse();
      ce_n = 1'b0; repeat (3) @(negedge clk);
      chk(col_addr == 8'h08, "R7 ignored with ce_n high", col_addr, 8'h08);
      bus_wr(1'b1, 1'b0, 16'h0070);
      bus_wr(1'b0, 1'b1, 16'h00FF);
      re_pulse();
      chk(col_addr == 8'h00, "R7 wrap", col_addr, 8'h00);

      // R4: new command restarts byte count
      bus_wr(1'b1, 1'b0, 16'h0000);
      bus_wr(1'b0, 1'b1, 16'h0022);
      bus_wr(1'b1, 1'b0, 16'h0070);
      bus_wr(1'b0, 1'b1, 16'h0033);
      chk(col_addr == 8'h33, "R4 count reset col", col_addr, 8'h33);
      chk(row_addr == 16'h1234, "R4 count reset row", row_addr, 16'h1234);

      // R6: both latch selects
      bus_wr(1'b1, 1'b1, 16'h0055);
      chk(seq_err == 1'b1, "R6 seq_err set", seq_err, 1);
      chk(cmd_code == 8'h70, "R6 cmd unchanged", cmd_code, 8'h70);
      chk(col_addr == 8'h33, "R6 col unchanged", col_addr, 8'h33);

      // R8: write lock blocks program and erase
      wp_n = 1'b0; repeat (2) @(negedge clk);
      bus_wr(1'b1, 1'b0, 16'h0010);
      repeat (5) @(negedge clk);
      chk(rb_n == 1'b1, "R8 program locked", rb_n, 1);
      bus_wr(1'b1, 1'b0, 16'h00D0);
      repeat (5) @(negedge clk);
      chk(rb_n == 1'b1, "R8 erase locked", rb_n, 1);
      wp_n = 1'b1; repeat (2) @(negedge clk);

      // R10, R12: program ignores chip select, writes ignored while busy
      bus_wr(1'b1, 1'b0, 16'h0010);
      ce_n = 1'b1; repeat (10) @(negedge clk);
      chk(rb_n == 1'b0, "R10 program survives ce_n high", rb_n, 0);
      ce_n = 1'b0; repeat (3) @(negedge clk);
      bus_wr(1'b0, 1'b0, 16'h1111);
      chk(din == 16'hBEEF, "R12 write ignored while busy", din, 16'hBEEF);
      wait_ready(n);
      chk(rb_n == 1'b1, "R10 program ends", rb_n, 1);
      repeat (3) @(negedge clk);

      // R10: erase length
      bus_wr(1'b1, 1'b0, 16'h00D0);
      wait_ready(n);
      chk(n == TE - 1, "R10 erase busy length", n, TE - 1);
      repeat (3) @(negedge clk);

      // R11: read abort versus don't-care build
      bus_wr(1'b1, 1'b0, 16'h0000);
      bus_wr(1'b0, 1'b1, 16'h0001);
      bus_wr(1'b0, 1'b1, 16'h0002);
      bus_wr(1'b0, 1'b1, 16'h0003);
      repeat (3) @(negedge clk);
      ce_n = 1'b1; repeat (8) @(negedge clk);
      chk(rb_n == 1'b1,   "R11 read aborted", rb_n, 1);
      chk(rb_n_1 == 1'b0, "R11 read continues with option", rb_n_1, 0);
      ce_n = 1'b0;
      n = 0;
      while (rb_n_1 == 1'b0 && n < 500) begin n++; @(negedge clk); end
      chk(rb_n_1 == 1'b1, "R11 optioned read completes", rb_n_1, 1);
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule